// File: doc/BRIEF.md
# Memory-Preserving Hard Reset Sequencer

This block sits inside a node or memory controller and decides what a hard reset does to the rest of the controller. It takes two views of the reset request, platform power-good and the external hard-reset pin, and passes both through a two-flop synchronizer into the core clock domain. The reset that follows power-up is always a full one. For later resets, a save-memory mode bit selects the path. It is sampled on the clock edge where the reset request is first seen and is held until the sequence ends.

On the full path, the block resets everything at once: the processor bus (with its power-on configuration), the firmware bus, all core logic including the array initializers, the maintenance engine and the scalability ports. It reports ready-to-deassert at once. On the preserving path, the block keeps the processor bus out of reset. It stalls new requests there, resets only the write-queue tracker and the scrubber, and disables the scalability ports. Refresh and calibration keep running. Before it reports ready-to-deassert and lets the sequence end, it waits for two things: the count of memory operations in flight must reach zero, and the current maintenance cycle must complete. When maintenance is disabled, a free-running timer closes a maintenance cycle every 240 clocks.

Every pin is a plain level or strobe. The block has no data stream and no valid/ready handshake.

Top module: `memsafe_reset_ctl`

## Requirements
- R1: While `pwr_good_i` is low, the block holds the full-reset output pattern (R2) whatever `save_mem_i` is.
- R2: On the full path, `cpu_rst_o`, `fw_rst_o`, `core_rst_o`, `wq_scrub_rst_o`, `port_dis_o`, `maint_rst_o` and `deassert_ok_o` are 1 and `bus_stall_o` is 0.
- R3: On the full path, `deassert_ok_o` is 1 from the first cycle. All outputs return to 0 on the third rising edge after `ext_rst_n_i` (or `pwr_good_i`) goes high.
- R4: The path is chosen from `save_mem_i` (1 = preserving) on the edge where the request is detected. A later change of `save_mem_i` has no effect until the block is back in normal operation.
- R5: On the preserving path, `fw_rst_o`, `wq_scrub_rst_o`, `port_dis_o` and `bus_stall_o` are 1, while `cpu_rst_o`, `core_rst_o` and `maint_rst_o` are 0.
- R6: The internal maintenance timer counts 0..239 and wraps. It is cleared only while the full path is active, so the preserving path does not restart it. With `maint_en_i` = 0, it ends a maintenance cycle in the cycle where it holds 239.
- R7: With `maint_en_i` = 1, only a `maint_done_i` pulse ends a maintenance cycle, and the timer has no effect.
- R8: On the preserving path, `deassert_ok_o` rises one edge after a cycle in which `inflight_i` is 0 and a maintenance-cycle end has been seen since entry (earlier or in that same cycle). Ends seen before entry do not count, and the flag stays set until exit.
- R9: The preserving path ends, with all outputs at 0, one edge after the point where `deassert_ok_o` is 1 and the synchronized request has gone. Until then every output holds its preserving value.
- R10: A falling `ext_rst_n_i` is acted on at the third rising edge: two synchronizer stages, then the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pwr_good_i | input | 1 | Platform power-good, asynchronous; low resets the block |
| ext_rst_n_i | input | 1 | External hard-reset request, active low, asynchronous |
| save_mem_i | input | 1 | Save-memory mode bit, 1 = preserving path |
| maint_en_i | input | 1 | Memory maintenance engine enabled |
| inflight_i | input | INFL_W | Number of memory operations still in flight |
| maint_done_i | input | 1 | One-cycle strobe: maintenance engine finished a cycle |
| cpu_rst_o | output | 1 | Processor-bus reset with power-on configuration |
| fw_rst_o | output | 1 | Firmware-bus reset and interface clear |
| core_rst_o | output | 1 | Reset of all core logic, array initialization held off |
| wq_scrub_rst_o | output | 1 | Reset of write-queue tracking and the scrubber |
| port_dis_o | output | 1 | Scalability ports disabled |
| bus_stall_o | output | 1 | Block new processor-bus requests |
| maint_rst_o | output | 1 | Maintenance engine and timer held in reset |
| deassert_ok_o | output | 1 | Ready for the reset to be released |

## Verification
On every cycle, the assertions check the following:
- the timer stays within its 240-state range and wraps from 239 to 0;
- the chosen path agrees with the mode bit seen on the detection edge;
- the ready flag never rises without a zero in-flight count and a maintenance-cycle end already seen;
- the bus stall never drops unless ready was already set.

Only the bench scenarios can show the rest. That covers the exact latencies of the synchronizer and the state register, and that the preserving path does not restart the 240-clock timer (the bench keeps its own timer model from the moment the full path ends). It also covers that maintenance ends seen before entry, and timer ticks while the engine is enabled, are ignored, and that the output pattern holds after the request has already gone.

// File: rtl/msr_pkg.sv
package msr_pkg;
  typedef enum logic [1:0] {
    ST_LIVE = 2'd0,
    ST_FULL = 2'd1,
    ST_KEEP = 2'd2
  } msr_state_e;
endpackage

// File: rtl/msr_sync2.sv
module msr_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/msr_maint_timer.sv
module msr_maint_timer #(
  parameter int PERIOD = 240,
  localparam int CW    = $clog2(PERIOD)
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hold_i,
  input  logic ext_en_i,
  input  logic ext_done_i,
  output logic done_o
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      cnt_q <= '0;
    else if (hold_i)  cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // an enabled engine reports its own cycle ends; otherwise the timer does
  assign done_o = ext_en_i ? ext_done_i : wrap;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q <= LAST);  // R6
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!arst_n)
    (cnt_q == LAST) |=> (cnt_q == '0));  // R6
  AST_CNT_RUNS: assert property (@(posedge clk) disable iff (!arst_n)
    (!hold_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));  // R6
endmodule

// File: rtl/msr_seq_fsm.sv
module msr_seq_fsm
  import msr_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       req_i,
  input  logic       save_i,
  input  logic       done_i,
  input  logic       qzero_i,
  output msr_state_e state_o,
  output logic       ready_o
);
  msr_state_e state_q;
  logic       seen_q, rdy_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_FULL;
      seen_q  <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_LIVE: begin
          seen_q <= 1'b0;
          rdy_q  <= 1'b0;
          if (req_i) state_q <= save_i ? ST_KEEP : ST_FULL;
        end
        ST_FULL: begin
          if (!req_i) state_q <= ST_LIVE;
        end
        ST_KEEP: begin
          if (done_i) seen_q <= 1'b1;
          if ((seen_q || done_i) && qzero_i) rdy_q <= 1'b1;
          if (!req_i && rdy_q) state_q <= ST_LIVE;
        end
        default: state_q <= ST_FULL;
      endcase
    end
  end

  assign state_o = state_q;
  assign ready_o = (state_q == ST_FULL) || (state_q == ST_KEEP && rdy_q);

  AST_PATH_FROM_MODE: assert property (@(posedge clk) disable iff (!arst_n)
    ($past(state_q) == ST_LIVE && state_q == ST_KEEP) |-> $past(save_i));  // R4
  AST_READY_NEEDS_END: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_KEEP && $rose(rdy_q)) |-> ($past(seen_q) || $past(done_i)));  // R8
  AST_KEEP_EXIT_READY: assert property (@(posedge clk) disable iff (!arst_n)
    ($past(state_q) == ST_KEEP && state_q == ST_LIVE) |-> $past(rdy_q));  // R9
endmodule

// File: rtl/memsafe_reset_ctl.sv
module memsafe_reset_ctl
  import msr_pkg::*;
#(
  parameter int MAINT_PERIOD = 240,
  parameter int INFL_W       = 6
) (
  input  logic              clk,
  input  logic              pwr_good_i,
  input  logic              ext_rst_n_i,
  input  logic              save_mem_i,
  input  logic              maint_en_i,
  input  logic [INFL_W-1:0] inflight_i,
  input  logic              maint_done_i,
  output logic              cpu_rst_o,
  output logic              fw_rst_o,
  output logic              core_rst_o,
  output logic              wq_scrub_rst_o,
  output logic              port_dis_o,
  output logic              bus_stall_o,
  output logic              maint_rst_o,
  output logic              deassert_ok_o
);
  logic [1:0] sync_q;
  logic       hr_req, cyc_end, full_act, keep_act;
  msr_state_e st;

  // bit 1 tracks power-good (reset to 0 while power is bad), bit 0 the pin
  msr_sync2 #(.W(2)) u_sync (
    .clk    (clk),
    .arst_n (pwr_good_i),
    .d_i    ({1'b1, ext_rst_n_i}),
    .q_o    (sync_q)
  );

  assign hr_req = !(sync_q[1] && sync_q[0]);

  msr_maint_timer #(.PERIOD(MAINT_PERIOD)) u_timer (
    .clk        (clk),
    .arst_n     (pwr_good_i),
    .hold_i     (full_act),
    .ext_en_i   (maint_en_i),
    .ext_done_i (maint_done_i),
    .done_o     (cyc_end)
  );

  msr_seq_fsm u_fsm (
    .clk     (clk),
    .arst_n  (pwr_good_i),
    .req_i   (hr_req),
    .save_i  (save_mem_i),
    .done_i  (cyc_end),
    .qzero_i (inflight_i == '0),
    .state_o (st),
    .ready_o (deassert_ok_o)
  );

  assign full_act       = (st == ST_FULL);
  assign keep_act       = (st == ST_KEEP);
  assign cpu_rst_o      = full_act;
  assign core_rst_o     = full_act;
  assign maint_rst_o    = full_act;
  assign fw_rst_o       = full_act || keep_act;
  assign wq_scrub_rst_o = full_act || keep_act;
  assign port_dis_o     = full_act || keep_act;
  assign bus_stall_o    = keep_act;

  AST_STALL_DROP_READY: assert property (@(posedge clk) disable iff (!pwr_good_i)
    $fell(bus_stall_o) |-> $past(deassert_ok_o));  // R9
  AST_READY_QUEUE_EMPTY: assert property (@(posedge clk) disable iff (!pwr_good_i)
    ($rose(deassert_ok_o) && bus_stall_o) |-> ($past(inflight_i) == '0));  // R8
endmodule

// File: tb/memsafe_reset_ctl_tb_top.sv
module memsafe_reset_ctl_tb_top;
  localparam int IW = 6;
  // output vector: {cpu, fw, core, wq, port, stall, maint, ok}
  localparam logic [7:0] PAT_LIVE   = 8'b0000_0000;
  localparam logic [7:0] PAT_FULL   = 8'b1111_1011;
  localparam logic [7:0] PAT_WAIT   = 8'b0101_1100;
  localparam logic [7:0] PAT_READY  = 8'b0101_1101;

  logic clk = 1'b0;
  logic pwr_good, ext_rst_n, save_mem, maint_en, maint_done;
  logic [IW-1:0] inflight;
  logic cpu_rst, fw_rst, core_rst, wq_rst, port_dis, stall, maint_rst, ok;
  int n_chk = 0, n_bad = 0, mdl = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  memsafe_reset_ctl #(.INFL_W(IW)) dut_i (
    .clk(clk), .pwr_good_i(pwr_good), .ext_rst_n_i(ext_rst_n),
    .save_mem_i(save_mem), .maint_en_i(maint_en), .inflight_i(inflight),
    .maint_done_i(maint_done), .cpu_rst_o(cpu_rst), .fw_rst_o(fw_rst),
    .core_rst_o(core_rst), .wq_scrub_rst_o(wq_rst), .port_dis_o(port_dis),
    .bus_stall_o(stall), .maint_rst_o(maint_rst), .deassert_ok_o(ok));

  wire [7:0] outs = {cpu_rst, fw_rst, core_rst, wq_rst, port_dis, stall, maint_rst, ok};

  // independent timer model: cleared while the full path shows, else 0..239
  always @(posedge clk) mdl <= cpu_rst ? 0 : (mdl + 1) % 240;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_powerup();
    chk("R1 power bad, mode=1", outs, PAT_FULL);
    pwr_good = 1'b1;
    tick(2);
    chk("R3 still full after 2 edges", outs, PAT_FULL);
    tick(1);
    chk("R3 released on 3rd edge", outs, PAT_LIVE);
  endtask

  task automatic t_full();
    save_mem = 1'b0; ext_rst_n = 1'b0;
    tick(2);
    chk("R10 not yet detected", outs, PAT_LIVE);
    tick(1);
    chk("R2 R10 full pattern", outs, PAT_FULL);
    save_mem = 1'b1;
    tick(5);
    chk("R4 mode change ignored", outs, PAT_FULL);
    ext_rst_n = 1'b1;
    tick(2);
    chk("R3 held 2 edges", outs, PAT_FULL);
    tick(1);
    chk("R3 released", outs, PAT_LIVE);
  endtask

  task automatic t_keep_timer();
    bit held = 1'b1;
    int k;
    maint_en = 1'b0; inflight = '0; save_mem = 1'b1; ext_rst_n = 1'b0;
    tick(3);
    chk("R5 preserving pattern", {outs[7:1], 1'b0}, {PAT_WAIT[7:1], 1'b0});
    save_mem = 1'b0; ext_rst_n = 1'b1;
    for (k = 0; k < 300 && !ok; k++) begin
      if (outs != PAT_WAIT) held = 1'b0;
      tick(1);
    end
    chk("R9 held until ready", held, 1'b1);
    chk("R6 ready one edge after timer end", mdl, 0);
    chk("R6 R4 ready pattern", outs, PAT_READY);
    for (int j = 0; j < 4 && outs != PAT_LIVE; j++) tick(1);
    chk("R9 exit to normal", outs, PAT_LIVE);
  endtask

  task automatic t_keep_ext();
    maint_en = 1'b1; inflight = '0; save_mem = 1'b1;
    maint_done = 1'b1; tick(1); maint_done = 1'b0;
    ext_rst_n = 1'b0;
    tick(3);
    chk("R5 entered preserving", outs, PAT_WAIT);
    tick(250);
    chk("R7 R8 timer and early end ignored", outs, PAT_WAIT);
    maint_done = 1'b1; tick(1); maint_done = 1'b0;
    chk("R8 end with empty queue", outs, PAT_READY);
    tick(2);
    chk("R8 ready sticky", outs, PAT_READY);
    ext_rst_n = 1'b1;
    tick(3);
    chk("R9 exit after request gone", outs, PAT_LIVE);
  endtask

  task automatic t_keep_order();
    maint_en = 1'b1; inflight = 6'd5; save_mem = 1'b1; ext_rst_n = 1'b0;
    tick(3);
    ext_rst_n = 1'b1;
    tick(5);
    chk("R9 held with request gone", outs, PAT_WAIT);
    maint_done = 1'b1; tick(1); maint_done = 1'b0;
    chk("R8 busy queue blocks ready", outs, PAT_WAIT);
    tick(3);
    chk("R8 still waiting", outs, PAT_WAIT);
    inflight = '0;
    tick(1);
    chk("R8 end then empty", outs, PAT_READY);
    tick(1);
    chk("R9 exit one edge after ready", outs, PAT_LIVE);
  endtask

  task automatic t_together();
    maint_en = 1'b1; inflight = 6'd2; save_mem = 1'b1; ext_rst_n = 1'b0;
    tick(3);
    chk("R5 preserving again", outs, PAT_WAIT);
    inflight = '0; maint_done = 1'b1; tick(1); maint_done = 1'b0;
    chk("R8 end and empty together", outs, PAT_READY);
    ext_rst_n = 1'b1;
    tick(3);
    chk("R9 back to normal", outs, PAT_LIVE);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    pwr_good = 1'b0; ext_rst_n = 1'b1; save_mem = 1'b1;
    maint_en = 1'b0; maint_done = 1'b0; inflight = '0;
    tick(3);
    t_powerup();
    t_full();
    t_keep_timer();
    t_keep_ext();
    t_keep_order();
    t_together();
    tick(2);
    finish_run();
  end
endmodule